// File: doc/BRIEF.md
# Serial Receiver with Break and Overrun Tracking

This block takes an asynchronous serial line and turns it into characters. The line is sampled on a 16x oversampling enable that comes from outside the block. Each finished character goes into a first-word-fall-through receive queue together with its own status: parity error, framing error and received-break. A consumer sees the head entry on the output pins and removes it with a one-cycle read strobe.

The block has a specific policy for line breaks. Suppose the line drops low partway through a character and stays low. The damaged character is still queued, with its framing flag and any parity flag. If the line then stays low for one more full character time, one extra entry is queued: an all-zero character with the break flag set. Only one break entry is produced per continuous low period. Break detection is armed again only after the line has been high for a full bit time.

Overrun is counted against an effective depth set at build time. This depth is the queue entries plus one holding stage that stands for the receive shift register. When a character completes and there is no room for it, it is dropped, the stored entries are kept, and a sticky overrun flag is raised.

Top module: `uart_rx_brk`

## Requirements
- R1: A low level on `rxd` starts a character only if it is still low at the 8th oversample tick after the falling edge was seen. A low pulse of 4 ticks produces no entry.
- R2: A frame is one start bit (low), then 8 data bits least significant bit first, then one even-parity bit, then one stop bit (high). Each data bit is sampled at the middle of its bit period. Characters come out on `rx_data` in arrival order.
- R3: `rx_perr` is set on an entry when the parity bit received differs from the XOR of the 8 data bits.
- R4: A stop bit sampled low queues the character with `rx_ferr` set.
- R5: If the line goes low partway through a character and stays low, the damaged character is queued first. It carries the data bits received before the drop, zeros in the bits after it, `rx_ferr` set and the matching parity flag. A second entry follows, with data 0, `rx_brk` set, and `rx_ferr` and `rx_perr` clear.
- R6: The break entry is queued only when the line stays low for a full frame time (11 bit times) after the stop-bit sample. A shorter low period leaves only the framing-error entry.
- R7: A continuous low period produces at most one break entry. After a break, a high period shorter than one bit time followed by more low produces no further entries.
- R8: With effective depth `EFF_DEPTH` (queue of `EFF_DEPTH-1` entries plus one holding stage), `EFF_DEPTH` unread characters leave `rx_overrun` low. The next character sets `rx_overrun` and is dropped, and the stored characters remain readable in order.
- R9: `rx_overrun` stays set until `ovr_clr` is pulsed.
- R10: While `rx_ready` is high, the outputs show the head entry, and the head does not change until `rd` is pulsed. `rd` while `rx_ready` is low has no effect.
- R11: After reset, `rx_ready` and `rx_overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit time |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| rd | input | 1 | Pop strobe for the head entry |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rx_ready | output | 1 | Queue holds at least one entry |
| rx_data | output | 8 | Head entry data |
| rx_perr | output | 1 | Head entry parity error |
| rx_ferr | output | 1 | Head entry framing error |
| rx_brk | output | 1 | Head entry is a break character |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest case to reach is the break sequence. It needs a character cut off at a chosen bit, then a low period that either just misses or just covers the extra frame time, then a short high blip that must not re-arm detection. The stimulus builds the line waveform bit by bit. A directed task sends a start bit and only the first k data bits, then holds the line low for a chosen number of bit times. The expected damaged data and parity flag are computed from the truncated value. Random frames with injected parity and stop faults run in between, and the overrun boundary is hit by sending exactly `EFF_DEPTH` and then `EFF_DEPTH+1` unread characters.

// File: rtl/rxb_pkg.sv
`timescale 1ns/1ps
package rxb_pkg;
    localparam int OSR       = 16;
    localparam int CHAR_BITS = 8;

    typedef enum logic [1:0] {PAR_NONE = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2} par_mode_e;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_LOW, S_REARM
    } rx_state_e;

    typedef struct packed {
        logic                 brk;
        logic                 ferr;
        logic                 perr;
        logic [CHAR_BITS-1:0] data;
    } entry_t;

    // Number of bit times in one frame for a parity setting.
    function automatic int frame_bits(par_mode_e m);
        return 2 + CHAR_BITS + ((m == PAR_NONE) ? 0 : 1);
    endfunction

    function automatic logic par_err(logic [CHAR_BITS-1:0] d, logic p, par_mode_e m);
        case (m)
            PAR_EVEN: return (^d) != p;
            PAR_ODD:  return (~^d) != p;
            default:  return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/rxb_sync.sv
`timescale 1ns/1ps
module rxb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxb_deser.sv
`timescale 1ns/1ps
module rxb_deser
    import rxb_pkg::*;
#(
    parameter par_mode_e PARITY = PAR_EVEN
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   rx,
    output logic   evt_v,
    output entry_t evt
);
    localparam int TW          = $clog2(OSR);
    localparam int BW          = $clog2(CHAR_BITS);
    localparam int FRAME_TICKS = frame_bits(PARITY) * OSR;
    localparam int LW          = $clog2(FRAME_TICKS + 1);
    localparam logic [TW-1:0] T_MID  = TW'(OSR / 2 - 1);
    localparam logic [TW-1:0] T_LAST = TW'(OSR - 1);
    localparam logic [BW-1:0] B_LAST = BW'(CHAR_BITS - 1);
    localparam logic [LW-1:0] L_LAST = LW'(FRAME_TICKS - 1);
    localparam entry_t BRK_ENTRY = '{brk: 1'b1, ferr: 1'b0, perr: 1'b0, data: '0};

    rx_state_e            state;
    logic [TW-1:0]        tcnt;
    logic [BW-1:0]        bcnt;
    logic [LW-1:0]        lcnt;
    logic [CHAR_BITS-1:0] shreg;
    logic                 par_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            tcnt    <= '0;
            bcnt    <= '0;
            lcnt    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            evt_v   <= 1'b0;
            evt     <= '0;
        end else begin
            evt_v <= 1'b0;
            if (tick) begin
                case (state)
                    S_IDLE: if (!rx) begin
                        state <= S_START;
                        tcnt  <= '0;
                    end
                    S_START: if (tcnt == T_MID) begin
                        tcnt  <= '0;
                        bcnt  <= '0;
                        state <= rx ? S_IDLE : S_DATA;
                    end else tcnt <= tcnt + 1'b1;
                    S_DATA: if (tcnt == T_LAST) begin
                        tcnt  <= '0;
                        shreg <= {rx, shreg[CHAR_BITS-1:1]};
                        if (bcnt == B_LAST) state <= (PARITY == PAR_NONE) ? S_STOP : S_PAR;
                        else                bcnt  <= bcnt + 1'b1;
                    end else tcnt <= tcnt + 1'b1;
                    S_PAR: if (tcnt == T_LAST) begin
                        tcnt    <= '0;
                        par_bit <= rx;
                        state   <= S_STOP;
                    end else tcnt <= tcnt + 1'b1;
                    S_STOP: if (tcnt == T_LAST) begin
                        tcnt     <= '0;
                        lcnt     <= '0;
                        evt_v    <= 1'b1;
                        evt.data <= shreg;
                        evt.perr <= par_err(shreg, par_bit, PARITY);
                        evt.ferr <= !rx;
                        evt.brk  <= 1'b0;
                        state    <= rx ? S_IDLE : S_LOW;
                    end else tcnt <= tcnt + 1'b1;
                    S_LOW: if (rx) begin
                        state <= S_IDLE;
                    end else if (lcnt == L_LAST) begin
                        evt_v <= 1'b1;
                        evt   <= BRK_ENTRY;
                        tcnt  <= '0;
                        state <= S_REARM;
                    end else lcnt <= lcnt + 1'b1;
                    S_REARM: if (!rx)          tcnt  <= '0;
                             else if (tcnt == T_LAST) state <= S_IDLE;
                             else              tcnt  <= tcnt + 1'b1;
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rxb_fifo.sv
`timescale 1ns/1ps
module rxb_fifo
    import rxb_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  entry_t din,
    input  logic   pop,
    output entry_t head,
    output logic   empty,
    output logic   full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] P_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] C_FULL = CW'(DEPTH);

    entry_t        mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == C_FULL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    function automatic logic [PW-1:0] step(logic [PW-1:0] p);
        return (p == P_LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_brk.sv
`timescale 1ns/1ps
module uart_rx_brk
    import rxb_pkg::*;
#(
    parameter int        EFF_DEPTH = 4,
    parameter par_mode_e PARITY    = PAR_EVEN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick16,
    input  logic                 rxd,
    input  logic                 rd,
    input  logic                 ovr_clr,
    output logic                 rx_ready,
    output logic [CHAR_BITS-1:0] rx_data,
    output logic                 rx_perr,
    output logic                 rx_ferr,
    output logic                 rx_brk,
    output logic                 rx_overrun
);
    localparam int QDEPTH = EFF_DEPTH - 1;

    logic   rx_s;
    logic   evt_v;
    entry_t evt;
    entry_t hold_q, head;
    logic   hold_v;
    logic   q_empty, q_full, q_push, ovr_set;

    rxb_sync #(.STAGES(2)) i_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(rx_s)
    );

    rxb_deser #(.PARITY(PARITY)) i_deser (
        .clk(clk), .rst(rst), .tick(tick16), .rx(rx_s), .evt_v(evt_v), .evt(evt)
    );

    // Holding stage stands in for the shift register when counting depth.
    assign q_push  = hold_v && !q_full;
    assign ovr_set = evt_v && hold_v && !q_push;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v     <= 1'b0;
            hold_q     <= '0;
            rx_overrun <= 1'b0;
        end else begin
            if (evt_v && !ovr_set) begin
                hold_q <= evt;
                hold_v <= 1'b1;
            end else if (q_push) begin
                hold_v <= 1'b0;
            end
            rx_overrun <= ovr_set | (rx_overrun & ~ovr_clr);
        end
    end

    rxb_fifo #(.DEPTH(QDEPTH)) i_fifo (
        .clk(clk), .rst(rst), .push(q_push), .din(hold_q),
        .pop(rd), .head(head), .empty(q_empty), .full(q_full)
    );

    assign rx_ready = !q_empty;
    assign rx_data  = head.data;
    assign rx_perr  = head.perr;
    assign rx_ferr  = head.ferr;
    assign rx_brk   = head.brk;
endmodule

// File: rtl/rxb_checker.sv
`timescale 1ns/1ps
module rxb_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         rd,
    input logic         ovr_clr,
    input logic         rx_ready,
    input logic [W-1:0] rx_data,
    input logic         rx_perr,
    input logic         rx_ferr,
    input logic         rx_brk,
    input logic         rx_overrun
);
    // R5: a break entry is an all-zero character without other errors
    a_r5_brk_clean: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && rx_brk) |-> (rx_data == '0 && !rx_ferr && !rx_perr));

    // R9: overrun holds until cleared
    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun && !ovr_clr) |=> rx_overrun);

    // R8: overrun can only appear while the queue holds data
    a_r8_ovr_when_full: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_ready));

    // R10: the head stays put without a read
    a_r10_head_stable: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && !rd) |=> (rx_ready && $stable(rx_data)));

    // R10: the queue empties only through a read
    a_r10_empty_on_read: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_ready) |-> $past(rd));
endmodule

bind uart_rx_brk rxb_checker #(.W(rxb_pkg::CHAR_BITS)) i_rxb_checker (
    .clk(clk), .rst(rst), .rd(rd), .ovr_clr(ovr_clr), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .rx_overrun(rx_overrun)
);

// File: tb/test_uart_rx_brk.sv
`timescale 1ns/1ps
module test_uart_rx_brk;
    localparam int EFF  = 4;
    localparam int CPT  = 4;          // clocks per oversample tick
    localparam int BITC = 16 * CPT;   // clocks per bit
    localparam int NF   = 11;         // bits per frame

    logic clk = 1'b0, rst = 1'b1, tick16 = 1'b0, rxd = 1'b1, rd = 1'b0, ovr_clr = 1'b0;
    logic rx_ready, rx_perr, rx_ferr, rx_brk, rx_overrun;
    logic [7:0] rx_data;

    int errors = 0, checks = 0;
    int tdiv = 0;
    logic [10:0] expq[$];   // {brk, ferr, perr, data}
    logic exp_ovr = 1'b0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tdiv   <= (tdiv == CPT - 1) ? 0 : tdiv + 1;
        tick16 <= (tdiv == 0);
    end

    uart_rx_brk i_uart_rx_brk (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .rd(rd), .ovr_clr(ovr_clr),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_brk(rx_brk), .rx_overrun(rx_overrun)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int clks);
        rxd = v;
        repeat (clks) @(negedge clk);
    endtask

    function automatic logic [10:0] mk(logic brk, logic ferr, logic perr, logic [7:0] d);
        return {brk, ferr, perr, d};
    endfunction

    task automatic model_push(input logic [10:0] e);
        if (expq.size() == EFF) exp_ovr = 1'b1;
        else expq.push_back(e);
    endtask

    task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        hold(1'b0, BITC);
        for (int i = 0; i < 8; i++) hold(d[i], BITC);
        hold((^d) ^ bad_par, BITC);
        hold(!bad_stop, BITC);
        hold(1'b1, 2 * BITC);
        model_push(mk(1'b0, bad_stop, bad_par, d));
    endtask

    // Start bit plus k data bits, then low for low_bits bit times.
    task automatic cut(input logic [7:0] d, input int k, input int low_bits);
        logic [7:0] part;
        hold(1'b0, BITC);
        for (int i = 0; i < k; i++) hold(d[i], BITC);
        hold(1'b0, low_bits * BITC);
        part = d & 8'((1 << k) - 1);
        model_push(mk(1'b0, 1'b1, ^part, part));
    endtask

    task automatic drain(input string req);
        logic [10:0] e, got;
        while (expq.size() > 0) begin
            e   = expq.pop_front();
            got = {rx_brk, rx_ferr, rx_perr, rx_data};
            check(rx_ready && got == e, req, {20'd0, rx_ready, got}, {20'd0, 1'b1, e});
            @(negedge clk) rd = 1'b1;
            @(negedge clk) rd = 1'b0;
        end
        check(!rx_ready, req, rx_ready, 0);
        check(rx_overrun == exp_ovr, req, rx_overrun, exp_ovr);
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(!rx_ready, "R11", rx_ready, 0);
        check(!rx_overrun, "R11", rx_overrun, 0);

        // R1: short low glitch ignored
        hold(1'b0, 4 * CPT);
        hold(1'b1, 2 * BITC);
        check(!rx_ready, "R1", rx_ready, 0);

        // R10: read on empty has no effect
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
        check(!rx_ready, "R10", rx_ready, 0);

        // R2 / R3 / R4 directed
        send(8'hA5, 0, 0);
        send(8'h00, 0, 0);
        send(8'hFF, 1, 0);
        drain("R2_R3");
        send(8'h3C, 0, 1);
        send(8'h81, 1, 1);
        drain("R4");

        // R5: cut after 3 bits, long low; break entry follows
        cut(8'h05, 3, (8 - 3) + 2 + NF + 2);
        model_push(mk(1'b1, 1'b0, 1'b0, 8'h00));
        hold(1'b1, 2 * BITC);
        drain("R5");

        // R6: cut with low period too short for a break
        cut(8'h06, 4, (8 - 4) + 2 + 3);
        hold(1'b1, 2 * BITC);
        drain("R6");

        // R7: long break, brief high blip, more low: single break entry
        cut(8'h01, 1, (8 - 1) + 2 + 3 * NF);
        model_push(mk(1'b1, 1'b0, 1'b0, 8'h00));
        hold(1'b1, BITC / 2);
        hold(1'b0, 2 * NF * BITC);
        hold(1'b1, 2 * BITC);
        drain("R7");
        send(8'h5A, 0, 0);
        drain("R7_rearm");

        // R8 / R9: overrun boundary
        for (int i = 0; i < EFF; i++) send(8'(8'h10 + i), 0, 0);
        check(!rx_overrun, "R8", rx_overrun, 0);
        send(8'hEE, 0, 0);
        check(rx_overrun, "R8", rx_overrun, 1);
        drain("R8");
        check(rx_overrun, "R9", rx_overrun, 1);
        @(negedge clk) ovr_clr = 1'b1;
        @(negedge clk) ovr_clr = 1'b0;
        exp_ovr = 1'b0;
        check(!rx_overrun, "R9", rx_overrun, 0);

        // Random batches within depth (R2, R3, R4)
        for (int b = 0; b < 10; b++) begin
            int n;
            n = 1 + int'($urandom % EFF);
            for (int j = 0; j < n; j++)
                send(8'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0);
            drain("R2_random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule